// File: doc/BRIEF.md
# Single-Bit Set/Clear and Bit-Test Branch Unit

This unit carries out the single-bit instructions of a small 8-bit processor core. The core fetches the instruction bytes and presents them all at once with a `start` pulse: the opcode, the direct-page address byte, the branch displacement byte and the address of the instruction. The opcode alone selects the operation and the bit number. The unit then uses a simple synchronous memory port that covers the 256-byte direct page. A set or clear operation runs as a read cycle followed by a write cycle that changes only the selected bit. A bit-test branch runs a single read and then reports the tested bit as the new carry value, together with the branch decision and the next program counter.

Results are valid during the single cycle in which `done` is high. Opcodes outside the four defined ranges cause no memory traffic and are reported through the `illegal` flag. The surrounding core is responsible for fetching instruction bytes and for every condition-code bit other than carry.

Top module: `bitop_unit`

## Requirements
- R1: After reset, `done`, `illegal`, `carry_we`, `taken`, `mem_req` and `busy` are all low.
- R2: Opcodes are decoded as follows, with bit number n from 0 to 7. 0x00+2n means branch if bit n is set. 0x01+2n means branch if bit n is clear. 0x10+2n means set bit n. 0x11+2n means clear bit n.
- R3: A set or clear operation first reads the addressed byte and then writes it back two cycles later to the same address. Only bit n is forced to 1 (set) or 0 (clear); the other seven bits keep their values.
- R4: For a set or clear operation, `done` pulses for one cycle in the cycle after the write cycle, and `carry_we` stays low. From the start edge to `done` takes 3 clock edges.
- R5: A bit-test branch performs exactly one read and never drives a write. `done` follows 2 edges after the start edge.
- R6: A branch is taken when the tested bit equals 1 for the "if set" form, or 0 for the "if clear" form. When taken, `pc_next` equals the instruction address + 3 + the sign-extended displacement, so the reach is -128 to +127 around the following instruction.
- R7: When a branch is not taken, `pc_next` equals the instruction address + 3.
- R8: On every bit-test branch, whether or not it is taken, `carry_we` is high during the `done` cycle and `carry_out` holds the tested bit.
- R9: An opcode of 0x20 or above causes no memory access. It raises `done` and `illegal` together in the cycle after the start edge, with `carry_we` low.
- R10: A `start` pulse that arrives while `busy` is high is ignored. It produces no memory access and no extra `done`.
- R11: `pc_next` wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction bytes are valid; accepted only when not busy |
| opcode | input | 8 | Opcode byte |
| addr_byte | input | 8 | Direct-page address byte |
| offset_byte | input | 8 | Signed branch displacement byte |
| pc_in | input | 16 | Address of the instruction's opcode byte |
| busy | output | 1 | An operation is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | 8 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Undefined opcode (valid with done) |
| carry_we | output | 1 | Carry update strobe (valid with done) |
| carry_out | output | 1 | New carry value |
| taken | output | 1 | Branch taken (valid with done) |
| pc_next | output | 16 | Next program counter (valid with done) |

## Verification
For a bit-test branch, the carry update and the program-counter redirect are produced in the same `done` cycle. A wrong bit selection or a wrong polarity therefore shows up as a mismatch in both at once. The bench drives both polarities on bits that are set and bits that are clear. It then compares `carry_out`, `taken` and `pc_next` together against the model, including for not-taken branches, where carry must still change. A second overlap is a new `start` that arrives while a set operation is still in its read/write sequence. The bench issues such a pulse and then checks that the memory byte it pointed at is unchanged and that no unexpected `done` appears.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    localparam int OPC_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_EVAL  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } state_e;

    // order matches {opcode[4], opcode[0]}
    typedef enum logic [1:0] {
        OP_BR_SET  = 2'b00,
        OP_BR_CLR  = 2'b01,
        OP_BIT_SET = 2'b10,
        OP_BIT_CLR = 2'b11
    } op_kind_e;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OPC_W-1:0]          opcode,
    output op_kind_e                  kind,
    output logic [$clog2(DATA_W)-1:0] bit_idx,
    output logic                      legal
);
    localparam int BIT_W    = $clog2(DATA_W);
    // two groups (branch, set/clr) of DATA_W bits, two polarities each
    localparam int OPC_SPAN = 4 * DATA_W;

    always_comb begin
        bit_idx = opcode[BIT_W:1];
        kind    = op_kind_e'({opcode[BIT_W+1], opcode[0]});
        legal   = (opcode < OPC_W'(OPC_SPAN));
    end
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]         rdata,
    input  logic [$clog2(DATA_W)-1:0] bit_idx,
    input  op_kind_e                  kind,
    output logic [DATA_W-1:0]         new_byte,
    output logic                      tested
);
    logic [DATA_W-1:0] mask;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (bit_idx == g[$clog2(DATA_W)-1:0]);
    end

    always_comb begin
        tested = |(rdata & mask);
        if (kind == OP_BIT_CLR) new_byte = rdata & ~mask;
        else                    new_byte = rdata | mask;
    end
endmodule

// File: rtl/bitop_target.sv
module bitop_target #(
    parameter int PC_W     = 16,
    parameter int DATA_W   = 8,
    parameter int INSN_LEN = 3
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] offset,
    output logic [PC_W-1:0]   fallthrough,
    output logic [PC_W-1:0]   target
);
    logic [PC_W-1:0] disp;

    always_comb begin
        disp        = {{(PC_W-DATA_W){offset[DATA_W-1]}}, offset};
        fallthrough = pc + PC_W'(INSN_LEN);
        target      = fallthrough + disp;
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int PC_W     = 16,
    parameter int INSN_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [ADDR_W-1:0] addr_byte,
    input  logic [DATA_W-1:0] offset_byte,
    input  logic [PC_W-1:0]   pc_in,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              illegal,
    output logic              carry_we,
    output logic              carry_out,
    output logic              taken,
    output logic [PC_W-1:0]   pc_next
);
    localparam int BIT_W = $clog2(DATA_W);

    typedef struct packed {
        state_e            state;
        op_kind_e          kind;
        logic [BIT_W-1:0]  bit_idx;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] offset;
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] wbyte;
        logic              illegal;
        logic              carry;
        logic              carry_we;
        logic              taken;
        logic [PC_W-1:0]   pc_next;
    } regs_t;

    regs_t q, d;

    op_kind_e          dec_kind;
    logic [BIT_W-1:0]  dec_bit;
    logic              dec_legal;
    logic [DATA_W-1:0] mod_byte;
    logic              mod_tested;
    logic [PC_W-1:0]   pc_fall;
    logic [PC_W-1:0]   pc_target;

    bitop_decode #(.DATA_W(DATA_W)) u_dec (
        .opcode  (opcode),
        .kind    (dec_kind),
        .bit_idx (dec_bit),
        .legal   (dec_legal)
    );

    bitop_modify #(.DATA_W(DATA_W)) u_mod (
        .rdata    (mem_rdata),
        .bit_idx  (q.bit_idx),
        .kind     (q.kind),
        .new_byte (mod_byte),
        .tested   (mod_tested)
    );

    bitop_target #(.PC_W(PC_W), .DATA_W(DATA_W), .INSN_LEN(INSN_LEN)) u_tgt (
        .pc          (q.pc),
        .offset      (q.offset),
        .fallthrough (pc_fall),
        .target      (pc_target)
    );

    logic is_branch_q;
    assign is_branch_q = (q.kind == OP_BR_SET) || (q.kind == OP_BR_CLR);

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.kind     = dec_kind;
                    d.bit_idx  = dec_bit;
                    d.addr     = addr_byte;
                    d.offset   = offset_byte;
                    d.pc       = pc_in;
                    d.illegal  = !dec_legal;
                    d.carry_we = 1'b0;
                    d.taken    = 1'b0;
                    d.state    = dec_legal ? ST_READ : ST_DONE;
                end
            end
            ST_READ: d.state = ST_EVAL;
            ST_EVAL: begin
                if (is_branch_q) begin
                    d.carry    = mod_tested;
                    d.carry_we = 1'b1;
                    d.taken    = (q.kind == OP_BR_SET) ? mod_tested : !mod_tested;
                    d.pc_next  = d.taken ? pc_target : pc_fall;
                    d.state    = ST_DONE;
                end else begin
                    d.wbyte = mod_byte;
                    d.state = ST_WRITE;
                end
            end
            ST_WRITE: d.state = ST_DONE;
            ST_DONE:  d.state = ST_IDLE;
            default:  d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        busy      = (q.state != ST_IDLE);
        mem_req   = (q.state == ST_READ) || (q.state == ST_WRITE);
        mem_we    = (q.state == ST_WRITE);
        mem_addr  = q.addr;
        mem_wdata = q.wbyte;
        done      = (q.state == ST_DONE);
        illegal   = done && q.illegal;
        carry_we  = done && q.carry_we;
        carry_out = q.carry;
        taken     = done && q.taken;
        pc_next   = q.pc_next;
    end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [7:0]        opcode,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              illegal,
    input logic              carry_we,
    input logic              taken
);
    // R3: write lands two cycles after a read of the same byte
    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(mem_req && !mem_we, 2) && ($past(mem_addr, 2) == mem_addr)));

    // R4: done directly after the write, without a carry update
    p_write_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (done && !carry_we));

    // R4: done is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: illegal opcode finishes next cycle
    p_illegal_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (opcode[7:5] != 3'b000)) |=> (done && illegal));

    // R9: illegal reports touch neither memory nor carry
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !mem_req && !carry_we));

    // R8: a taken branch always updates carry
    p_taken_has_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> carry_we);

    // R10: memory traffic only inside an accepted operation
    p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .opcode   (opcode),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done),
    .illegal  (illegal),
    .carry_we (carry_we),
    .taken    (taken)
);

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  addr_byte = '0;
    logic [7:0]  offset_byte = '0;
    logic [15:0] pc_in = '0;
    logic        busy, mem_req, mem_we, done, illegal, carry_we, carry_out, taken;
    logic [7:0]  mem_addr, mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] pc_next;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit u0 (.*);

    logic [7:0] mem [256];
    logic [7:0] shadow [256];
    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    typedef struct {
        logic        ill;
        logic        cwe;
        logic        c;
        logic        tk;
        logic [15:0] pc;
        logic        chk_mem;
        logic [7:0]  a;
        logic [7:0]  b;
        int          lat;
        int          t0;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(illegal == e.ill, e.req, "illegal", illegal, e.ill);
                check(carry_we == e.cwe, e.req, "carry_we", carry_we, e.cwe);
                check((cyc - e.t0) == e.lat, e.req, "latency", cyc - e.t0, e.lat);
                if (e.cwe) begin
                    check(carry_out == e.c, {e.req, "/R8"}, "carry", carry_out, e.c);
                    check(taken == e.tk, e.req, "taken", taken, e.tk);
                    check(pc_next == e.pc, e.req, "pc_next", pc_next, e.pc);
                end
                if (e.chk_mem)
                    check(mem[e.a] == e.b, e.req, "memory byte", mem[e.a], e.b);
            end
        end
    end

    // driver: computes expectations from the requirements
    task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] off,
                         input logic [15:0] pc, input string req, input bit poke = 0,
                         input logic [7:0] poke_addr = 8'h00);
        exp_t e;
        int n;
        logic bv;
        @(negedge clk);
        while (busy) @(negedge clk);
        n = int'(op[3:1]);
        e.ill = 0; e.cwe = 0; e.c = 0; e.tk = 0; e.pc = '0;
        e.chk_mem = 1; e.a = a; e.req = req;
        if (op >= 8'h20) begin
            e.ill = 1; e.lat = 1;
            e.b = shadow[a];
        end else if (op[4]) begin
            if (op[0]) shadow[a][n] = 1'b0;
            else       shadow[a][n] = 1'b1;
            e.b = shadow[a]; e.lat = 4;
        end else begin
            bv = shadow[a][n];
            e.cwe = 1; e.c = bv;
            e.tk = op[0] ? !bv : bv;
            e.pc = e.tk ? (pc + 16'd3 + {{8{off[7]}}, off}) : (pc + 16'd3);
            e.b = shadow[a]; e.lat = 3;
        end
        e.t0 = cyc;
        sb.push_back(e);
        start = 1; opcode = op; addr_byte = a; offset_byte = off; pc_in = pc;
        @(negedge clk);
        start = 0;
        if (poke) begin
            // R10: start while busy must be ignored
            start = 1; opcode = 8'h10; addr_byte = poke_addr;
            @(negedge clk);
            start = 0;
        end
        while (sb.size() != 0) @(negedge clk);
    endtask

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'((i * 37 + 5) & 8'hFF);
            shadow[i] = mem[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!done && !illegal && !carry_we && !taken && !mem_req && !busy,
              "R1", "reset outputs", {done, illegal, carry_we, taken, mem_req, busy}, 0);
        rst_n = 1;

        // R2 / R3 / R4: set and clear, boundary bits and addresses
        issue(8'h10, 8'h00, 8'h00, 16'h0000, "R3");        // set bit0 @00
        issue(8'h1E, 8'hFF, 8'h00, 16'h0000, "R3");        // set bit7 @FF
        issue(8'h11, 8'h00, 8'h00, 16'h0000, "R2");        // clear bit0 @00
        issue(8'h1F, 8'hFF, 8'h00, 16'h0000, "R2");        // clear bit7 @FF
        issue(8'h18, 8'h40, 8'h00, 16'h0000, "R4");        // set bit4
        issue(8'h18, 8'h40, 8'h00, 16'h0000, "R4");        // set again: no change
        issue(8'h15, 8'h81, 8'h00, 16'h0000, "R3");        // clear bit2
        for (int k = 0; k < 8; k++)
            issue(8'(8'h10 + 2*k + (k & 1)), 8'(8'h20 + k), 8'h00, 16'h0000, "R2");

        // R5 / R6 / R7 / R8: branches on a known byte
        shadow[8'h30] = 8'h00; mem[8'h30] = 8'h00;
        issue(8'h16, 8'h30, 8'h00, 16'h0000, "R3");        // set bit3 @30
        issue(8'h06, 8'h30, 8'h7F, 16'h1000, "R6");        // br set bit3, taken +127
        issue(8'h07, 8'h30, 8'h10, 16'h1000, "R7");        // br clr bit3, not taken
        issue(8'h00, 8'h30, 8'h80, 16'h2000, "R7");        // br set bit0, not taken
        issue(8'h01, 8'h30, 8'h80, 16'h2000, "R6");        // br clr bit0, taken -128
        issue(8'h0E, 8'hFF, 8'hFD, 16'h3456, "R5");        // offset -3: loops to self
        issue(8'h0F, 8'hFF, 8'h00, 16'h3456, "R8");        // carry reflects bit either way
        // R11: wrap
        issue(8'h01, 8'h30, 8'h05, 16'hFFFE, "R11");       // taken, wraps past FFFF
        issue(8'h00, 8'h30, 8'h05, 16'hFFFE, "R11");       // not taken, wraps

        // R9: illegal opcodes
        issue(8'h20, 8'h30, 8'h00, 16'h0000, "R9");
        issue(8'hFF, 8'h40, 8'h00, 16'h0000, "R9");
        issue(8'h80, 8'h00, 8'h00, 16'h0000, "R9");

        // R10: start while busy ignored (poke targets byte 0x50 bit 0)
        shadow[8'h50] = 8'hAA; mem[8'h50] = 8'hAA;
        issue(8'h12, 8'h51, 8'h00, 16'h0000, "R10", 1, 8'h50);
        repeat (6) @(negedge clk);
        check(mem[8'h50] == 8'hAA, "R10", "poked byte", mem[8'h50], 8'hAA);
        check(sb.size() == 0 && !busy, "R10", "idle after poke", busy, 0);
        issue(8'h02, 8'h50, 8'h00, 16'h0100, "R10");       // bit1 of AA is 1 -> taken

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule